// File: doc/BRIEF.md
# Multi-Counter Event Monitoring Unit

This block counts hardware events for performance analysis. It has eight general counters and one fixed counter. Each general counter has its own configuration word. That word holds a threshold, an invert flag, an edge-detect flag, a local enable and an interrupt-on-overflow flag. It also holds an event code and a qualifier mask, which the decode logic outside the block reads. Every cycle, each general lane presents an 8-bit event value. Depending on its configuration, the counter either adds that value or adds one when the threshold test passes.

Software programs the unit through a simple word-addressed write port and a separate combinational read port. Counting needs both the local enable in the lane's configuration and the lane's bit in a global enable word. Wrapping counters raise sticky flags in a status word. A separate clear word removes those flags, with write-one-to-clear semantics. When a counter that has interrupt-on-overflow set wraps, the block raises the summary interrupt flag, and the interrupt output stays high until software clears it.

Each lane also keeps an occupancy accumulator that adds the raw lane value every cycle. Writing a configuration word with its reset bit set zeroes that accumulator.

Top module: `evt_mon_unit`

## Requirements
- R1: After reset, every readable address returns zero and `irq` is low.
- R2: Word map: 0-7 are the lane configurations, 8-15 the lane counters, 16 the fixed counter, 17 the global enable word (bit i enables lane i, bit 32 enables the fixed counter), 18 the status word, 19 the clear word (reads 0), and 20-27 the occupancy accumulators. Writes to 18, 20-27 and 28-31 are ignored. Configuration bits 7:0 are the event code, 15:8 the qualifier mask, 18 edge detect, 20 interrupt-on-overflow, 22 local enable, 23 invert and 31:24 the threshold. All other bits read 0, so a write of all ones reads back as 0x00000000FFD4FFFF.
- R3: A lane counter changes only when its configuration bit 22 and its global enable bit are both set.
- R4: With threshold 0, an active lane adds its 8-bit event value every cycle.
- R5: With a nonzero threshold, an active lane adds 1 in a cycle where value >= threshold, or value < threshold when bit 23 is set.
- R6: With edge detect set and a nonzero threshold, an active lane adds 1 only when its comparison is true and was false in the previous cycle. The previous result is tracked every cycle, even when the lane is disabled.
- R7: A lane counter wrapping from all ones to zero sets status bit i. The fixed counter adds 1 per cycle while enabled, and its wrap sets status bit 32. Any wrap also sets the change flag, status bit 63.
- R8: A wrap of a lane whose bit 20 is set sets status bit 61. `irq` equals status bit 61 and stays high until that bit is cleared.
- R9: Writing 1 to bit 0-7, 32, 61 or 63 of the clear word clears the same status bit, and zero bits have no effect. If a flag is set and cleared in the same cycle, it ends up set.
- R10: Each occupancy accumulator adds its lane value every cycle. A configuration write with bit 17 set zeroes it, and that cycle's value is dropped. Writing 0 to bit 17 has no effect, and bit 17 always reads 0.
- R11: A write to a counter loads it, and the write takes priority over counting in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe |
| wrAddr | input | 5 | Write word address |
| wrData | input | 64 | Write data |
| rdAddr | input | 5 | Read word address |
| rdData | output | 64 | Combinational read data |
| evtVal | input | 64 | Eight 8-bit lane event values, lane i at bits 8i+7:8i |
| irq | output | 1 | Overflow interrupt |

## Verification
Two events can land in the same cycle. The first pair is a counter wrapping while software writes the clear word for that flag. The second pair is a counter being loaded while its lane presents a nonzero event. The bench preloads a counter to all ones, then issues the clear write in the exact cycle the final increment arrives, and expects the flag and the interrupt to survive. In the same way, it loads a counter during an active event and expects exactly the written value. A behavioural model is compared on every clock, and random traffic then produces many more such collisions.

// File: rtl/evt_mon_pkg.sv
package evt_mon_pkg;
  localparam int NCTR   = 8;
  localparam int EVT_W  = 8;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 64;

  localparam int A_CFG  = 0;
  localparam int A_CTR  = 8;
  localparam int A_FIX  = 16;
  localparam int A_GCTL = 17;
  localparam int A_STAT = 18;
  localparam int A_OVFC = 19;
  localparam int A_OCC  = 20;

  localparam int B_OCCRST = 17;
  localparam int B_EDGE   = 18;
  localparam int B_PMI    = 20;
  localparam int B_LEN    = 22;
  localparam int B_INV    = 23;
  localparam int B_THR    = 24;
  localparam int B_FIX    = 32;
  localparam int B_PMIST  = 61;
  localparam int B_CHG    = 63;

  localparam logic [31:0] CFG_KEEP = 32'hFFD4_FFFF;

  typedef struct packed {
    logic [NCTR-1:0] ctrWe;
    logic            fixWe;
    logic [NCTR-1:0] occClr;
    logic [NCTR-1:0] clrOvf;
    logic            clrFix;
    logic            clrPmi;
    logic            clrChg;
  } strobe_t;
endpackage

// File: rtl/evt_mon_ctrl.sv
module evt_mon_ctrl
  import evt_mon_pkg::*;
(
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       wrEn,
  input  logic [ADDR_W-1:0]          wrAddr,
  input  logic [DATA_W-1:0]          wrData,
  output logic [NCTR-1:0][31:0]      cfgQ,
  output logic [NCTR-1:0]            gEnQ,
  output logic                       fixEnQ,
  output strobe_t                    stb
);
  logic unusedBits;
  assign unusedBits = ^{wrData[60:33], wrData[62]};

  always_comb begin
    stb = '0;
    if (wrEn) begin
      for (int i = 0; i < NCTR; i++) begin
        if (wrAddr == ADDR_W'(A_CTR + i)) stb.ctrWe[i] = 1'b1;
        if (wrAddr == ADDR_W'(A_CFG + i) && wrData[B_OCCRST]) stb.occClr[i] = 1'b1;
      end
      stb.fixWe = (wrAddr == ADDR_W'(A_FIX));
      if (wrAddr == ADDR_W'(A_OVFC)) begin
        stb.clrOvf = wrData[NCTR-1:0];
        stb.clrFix = wrData[B_FIX];
        stb.clrPmi = wrData[B_PMIST];
        stb.clrChg = wrData[B_CHG];
      end
    end
  end

  for (genvar gi = 0; gi < NCTR; gi++) begin : g_cfg
    always_ff @(posedge clk) begin
      if (!rstN) cfgQ[gi] <= '0;
      else if (wrEn && wrAddr == ADDR_W'(A_CFG + gi)) cfgQ[gi] <= wrData[31:0] & CFG_KEEP;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gEnQ   <= '0;
      fixEnQ <= 1'b0;
    end else if (wrEn && wrAddr == ADDR_W'(A_GCTL)) begin
      gEnQ   <= wrData[NCTR-1:0];
      fixEnQ <= wrData[B_FIX];
    end
  end
endmodule

// File: rtl/evt_mon_dpath.sv
module evt_mon_dpath
  import evt_mon_pkg::*;
#(
  parameter int CtrW = 48,
  parameter int OccW = 32
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  strobe_t                     stb,
  input  logic [CtrW-1:0]             ldData,
  input  logic [NCTR-1:0][31:0]       cfgQ,
  input  logic [NCTR-1:0]             gEn,
  input  logic                        fixEn,
  input  logic [NCTR-1:0][EVT_W-1:0]  evtArr,
  output logic [NCTR-1:0][CtrW-1:0]   ctrV,
  output logic [CtrW-1:0]             fixV,
  output logic [NCTR-1:0][OccW-1:0]   occV,
  output logic [DATA_W-1:0]           statusV,
  output logic                        irq
);
  localparam int SumW = CtrW + 1;

  logic [NCTR-1:0] ovfSet, pmiHit;
  logic [NCTR-1:0] ovfQ;
  logic            fixOvfQ, pmiQ, chgQ, fixWrap;

  for (genvar gi = 0; gi < NCTR; gi++) begin : g_lane
    logic [EVT_W-1:0] thr, inc;
    logic             cmp, hit, act, prevQ;
    logic [SumW-1:0]  sum;
    logic [CtrW-1:0]  ctrQ;
    logic [OccW-1:0]  occQ;
    logic             unusedCfg;

    assign unusedCfg = ^{cfgQ[gi][21], cfgQ[gi][19], cfgQ[gi][17:0]};
    assign thr = cfgQ[gi][B_THR +: EVT_W];
    assign cmp = cfgQ[gi][B_INV] ? (evtArr[gi] < thr) : (evtArr[gi] >= thr);
    assign hit = cfgQ[gi][B_EDGE] ? (cmp & ~prevQ) : cmp;
    assign inc = (thr == '0) ? evtArr[gi] : EVT_W'(hit);
    assign act = cfgQ[gi][B_LEN] & gEn[gi];
    assign sum = {1'b0, ctrQ} + SumW'(inc);
    assign ovfSet[gi] = act & sum[CtrW] & ~stb.ctrWe[gi];
    assign pmiHit[gi] = ovfSet[gi] & cfgQ[gi][B_PMI];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        prevQ <= 1'b0;
        ctrQ  <= '0;
        occQ  <= '0;
      end else begin
        prevQ <= cmp;
        if (stb.ctrWe[gi]) ctrQ <= ldData;
        else if (act)      ctrQ <= sum[CtrW-1:0];
        if (stb.occClr[gi]) occQ <= '0;
        else                occQ <= occQ + OccW'(evtArr[gi]);
      end
    end

    assign ctrV[gi] = ctrQ;
    assign occV[gi] = occQ;
  end

  assign fixWrap = fixEn & (&fixV) & ~stb.fixWe;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fixV    <= '0;
      ovfQ    <= '0;
      fixOvfQ <= 1'b0;
      pmiQ    <= 1'b0;
      chgQ    <= 1'b0;
    end else begin
      if (stb.fixWe)  fixV <= ldData;
      else if (fixEn) fixV <= fixV + 1'b1;
      ovfQ    <= (ovfQ & ~stb.clrOvf) | ovfSet;
      fixOvfQ <= (fixOvfQ & ~stb.clrFix) | fixWrap;
      pmiQ    <= (pmiQ & ~stb.clrPmi) | (|pmiHit);
      chgQ    <= (chgQ & ~stb.clrChg) | (|ovfSet) | fixWrap;
    end
  end

  always_comb begin
    statusV = '0;
    statusV[NCTR-1:0] = ovfQ;
    statusV[B_FIX]    = fixOvfQ;
    statusV[B_PMIST]  = pmiQ;
    statusV[B_CHG]    = chgQ;
  end

  assign irq = pmiQ;
endmodule

// File: rtl/evt_mon_unit.sv
module evt_mon_unit
  import evt_mon_pkg::*;
#(
  parameter int CtrW = 48,
  parameter int OccW = 32
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    wrEn,
  input  logic [ADDR_W-1:0]       wrAddr,
  input  logic [DATA_W-1:0]       wrData,
  input  logic [ADDR_W-1:0]       rdAddr,
  output logic [DATA_W-1:0]       rdData,
  input  logic [NCTR*EVT_W-1:0]   evtVal,
  output logic                    irq
);
  strobe_t                      stb;
  logic [NCTR-1:0][31:0]        cfgQ;
  logic [NCTR-1:0]              gEn;
  logic                         fixEn;
  logic [NCTR-1:0][EVT_W-1:0]   evtArr;
  logic [NCTR-1:0][CtrW-1:0]    ctrV;
  logic [CtrW-1:0]              fixV;
  logic [NCTR-1:0][OccW-1:0]    occV;
  logic [DATA_W-1:0]            statusV;

  assign evtArr = evtVal;

  evt_mon_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .cfgQ(cfgQ), .gEnQ(gEn), .fixEnQ(fixEn), .stb(stb)
  );

  evt_mon_dpath #(.CtrW(CtrW), .OccW(OccW)) i_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .ldData(wrData[CtrW-1:0]),
    .cfgQ(cfgQ), .gEn(gEn), .fixEn(fixEn), .evtArr(evtArr),
    .ctrV(ctrV), .fixV(fixV), .occV(occV), .statusV(statusV), .irq(irq)
  );

  always_comb begin
    rdData = '0;
    for (int i = 0; i < NCTR; i++) begin
      if (rdAddr == ADDR_W'(A_CFG + i)) rdData = DATA_W'(cfgQ[i]);
      if (rdAddr == ADDR_W'(A_CTR + i)) rdData = DATA_W'(ctrV[i]);
      if (rdAddr == ADDR_W'(A_OCC + i)) rdData = DATA_W'(occV[i]);
    end
    if (rdAddr == ADDR_W'(A_FIX)) rdData = DATA_W'(fixV);
    if (rdAddr == ADDR_W'(A_GCTL)) begin
      rdData[NCTR-1:0] = gEn;
      rdData[B_FIX]    = fixEn;
    end
    if (rdAddr == ADDR_W'(A_STAT)) rdData = statusV;
  end
endmodule

// File: rtl/evt_mon_chk.sv
module evt_mon_chk
  import evt_mon_pkg::*;
#(
  parameter int CtrW = 48,
  parameter int OccW = 32
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       wrEn,
  input logic [ADDR_W-1:0]          wrAddr,
  input logic [31:0]                wLo,
  input logic [NCTR-1:0][31:0]      cfgQ,
  input logic [NCTR-1:0]            gEn,
  input logic [NCTR-1:0][CtrW-1:0]  ctrV,
  input logic [NCTR-1:0][OccW-1:0]  occV,
  input logic [DATA_W-1:0]          statusV,
  input logic                       irq
);
  for (genvar gi = 0; gi < NCTR; gi++) begin : g_chk
    AST_CFG_WRITE: assert property (@(posedge clk) disable iff (!rstN)
      (wrEn && wrAddr == ADDR_W'(A_CFG + gi)) |=> (cfgQ[gi][B_OCCRST] == 1'b0 && cfgQ[gi][7:0] == $past(wLo[7:0]))); // R2
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
      (!(gEn[gi] && cfgQ[gi][B_LEN]) && !(wrEn && wrAddr == ADDR_W'(A_CTR + gi))) |=> $stable(ctrV[gi])); // R3
    AST_OCC_ZERO: assert property (@(posedge clk) disable iff (!rstN)
      (wrEn && wrAddr == ADDR_W'(A_CFG + gi) && wLo[B_OCCRST]) |=> (occV[gi] == '0)); // R10
  end

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && wrAddr == ADDR_W'(A_OVFC)) |=> ((statusV & $past(statusV)) == $past(statusV))); // R9
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> (statusV[NCTR-1:0] != '0)); // R8
endmodule

bind evt_mon_unit evt_mon_chk #(.CtrW(CtrW), .OccW(OccW)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wLo(wrData[31:0]),
  .cfgQ(cfgQ), .gEn(gEn), .ctrV(ctrV), .occV(occV), .statusV(statusV), .irq(irq)
);

// File: tb/test_evt_mon_unit.sv
module test_evt_mon_unit;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int CW = 48;
  localparam int OW = 32;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [4:0]  wrAddr = '0;
  logic [63:0] wrData = '0;
  logic [4:0]  rdAddr = '0;
  logic [63:0] rdData;
  logic [63:0] evtVal = '0;
  logic        irq;

  int    nChk = 0;
  int    nBad = 0;
  bit    done = 1'b0;
  string phaseTag = "";
  logic [4:0] scan = '0;

  always #2 clk = ~clk;

  evt_mon_unit i_evt_mon_unit (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .evtVal(evtVal), .irq(irq)
  );

  // behavioural reference
  logic [31:0]   mCfg [8];
  logic [CW-1:0] mCtr [8];
  logic [OW-1:0] mOcc [8];
  bit            mPrev [8];
  logic [7:0]    mEn;
  bit            mFixEn;
  logic [CW-1:0] mFix;
  logic [63:0]   mSt;

  always @(posedge clk) begin : mdl
    logic [63:0] nst;
    logic [7:0]  v, th;
    logic [CW:0] s;
    int          add;
    bit          c, h;
    if (!rstN) begin
      for (int i = 0; i < 8; i++) begin
        mCfg[i] = '0; mCtr[i] = '0; mOcc[i] = '0; mPrev[i] = 1'b0;
      end
      mEn = '0; mFixEn = 1'b0; mFix = '0; mSt = '0;
    end else begin
      nst = mSt;
      if (wrEn && wrAddr == 5'd19)
        nst = nst & ~(wrData & 64'hA000_0001_0000_00FF);
      for (int i = 0; i < 8; i++) begin
        v  = evtVal[i*8 +: 8];
        th = mCfg[i][31:24];
        c  = mCfg[i][23] ? (v < th) : (v >= th);
        h  = mCfg[i][18] ? (c && !mPrev[i]) : c;
        add = (th == 0) ? int'(v) : (h ? 1 : 0);
        mPrev[i] = c;
        if (wrEn && wrAddr == 5'(8 + i)) mCtr[i] = wrData[CW-1:0];
        else if (mCfg[i][22] && mEn[i]) begin
          s = {1'b0, mCtr[i]} + (CW+1)'(add);
          mCtr[i] = s[CW-1:0];
          if (s[CW]) begin
            nst[i] = 1'b1; nst[63] = 1'b1;
            if (mCfg[i][20]) nst[61] = 1'b1;
          end
        end
        if (wrEn && wrAddr == 5'(i) && wrData[17]) mOcc[i] = '0;
        else mOcc[i] = mOcc[i] + OW'(v);
      end
      if (wrEn && wrAddr == 5'd16) mFix = wrData[CW-1:0];
      else if (mFixEn) begin
        if (mFix == {CW{1'b1}}) begin nst[32] = 1'b1; nst[63] = 1'b1; end
        mFix = mFix + 1'b1;
      end
      if (wrEn && wrAddr < 5'd8) mCfg[wrAddr[2:0]] = wrData[31:0] & 32'hFFD4_FFFF;
      if (wrEn && wrAddr == 5'd17) begin mEn = wrData[7:0]; mFixEn = wrData[32]; end
      mSt = nst;
    end
  end

  function automatic logic [63:0] mRead(input logic [4:0] a);
    if (a < 5'd8)  return {32'b0, mCfg[a[2:0]]};
    if (a < 5'd16) return 64'(mCtr[a[2:0]]);
    if (a == 5'd16) return 64'(mFix);
    if (a == 5'd17) return {31'b0, mFixEn, 24'b0, mEn};
    if (a == 5'd18) return mSt;
    if (a >= 5'd20 && a < 5'd28) return 64'(mOcc[3'(a - 5'd20)]);
    return '0;
  endfunction

  function automatic string tagOf(input logic [4:0] a);
    if (a < 5'd8)   return "R2 cfg";
    if (a < 5'd16)  return "R3 counter";
    if (a == 5'd16) return "R7 fixed";
    if (a == 5'd18) return "R9 status";
    if (a >= 5'd20 && a < 5'd28) return "R10 occupancy";
    return "R2 map";
  endfunction

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s act=%h exp=%h t=%0t", phaseTag, tag, act, exp, $time);
    end
  endtask

  task automatic tick(input bit we, input logic [4:0] a, input logic [63:0] d, input logic [63:0] ev);
    @(negedge clk);
    rdAddr = scan;
    #0.2;
    chk(rdData, mRead(scan), tagOf(scan));
    chk({63'b0, irq}, {63'b0, mSt[61]}, "R8 irq");
    scan = scan + 1'b1;
    wrEn = we; wrAddr = a; wrData = d; evtVal = ev;
  endtask

  task automatic idle(input logic [63:0] ev);
    tick(1'b0, 5'd0, 64'd0, ev);
  endtask

  task automatic peek(input logic [4:0] a, input logic [63:0] e, input string tag);
    rdAddr = a;
    #0.2;
    chk(rdData, e, tag);
  endtask

  initial begin
    #800000;
    if (!done) begin
      nBad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", nChk, nBad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    phaseTag = "R1";
    for (int k = 0; k < 32; k++) idle('0);
    phaseTag = "";

    // R2: writable field mask, bit 17 reads zero
    tick(1'b1, 5'd0, 64'hFFFF_FFFF_FFFF_FFFF, '0);
    idle('0);
    peek(5'd0, 64'h0000_0000_FFD4_FFFF, "R2 readback");
    tick(1'b1, 5'd0, 64'd0, '0);

    // R4 raw add, R3 enable gating
    tick(1'b1, 5'd0, 64'h0040_0000, '0);
    tick(1'b1, 5'd1, 64'h0040_0000, '0);
    tick(1'b1, 5'd17, 64'h5, '0);
    for (int k = 0; k < 5; k++) idle(64'h0003_0303);
    idle('0);
    peek(5'd8, 64'd15, "R4 raw sum");
    peek(5'd9, 64'd0, "R3 global off");
    peek(5'd10, 64'd0, "R3 local off");

    // R5 threshold and inverted threshold
    tick(1'b1, 5'd3, 64'h0540_0000, '0);
    tick(1'b1, 5'd4, 64'h05C0_0000, '0);
    tick(1'b1, 5'd17, 64'h1D, '0);
    idle(64'h0000_0007_0700_0000);
    idle(64'h0000_0005_0500_0000);
    idle(64'h0000_0004_0400_0000);
    idle(64'h0000_0000_0000_0000);
    idle(64'h0000_0009_0900_0000);
    idle('0);
    peek(5'd11, 64'd3, "R5 at-or-above");
    peek(5'd12, 64'd2, "R5 inverted");
    tick(1'b1, 5'd4, 64'd0, '0);

    // R6 edge detect
    tick(1'b1, 5'd5, 64'h0544_0000, '0);
    tick(1'b1, 5'd17, 64'h2D, '0);
    idle(64'h0000_0600_0000_0000);
    idle(64'h0000_0600_0000_0000);
    idle(64'h0000_0000_0000_0000);
    idle(64'h0000_0700_0000_0000);
    idle(64'h0000_0800_0000_0000);
    idle(64'h0000_0200_0000_0000);
    idle(64'h0000_0900_0000_0000);
    idle('0);
    peek(5'd13, 64'd3, "R6 rising edges");

    // R11 load, R7 wrap, R8 interrupt
    tick(1'b1, 5'd6, 64'h0050_0000, '0);
    tick(1'b1, 5'd17, 64'h6D, '0);
    tick(1'b1, 5'd14, 64'h0000_FFFF_FFFF_FFFE, '0);
    idle('0);
    peek(5'd14, 64'h0000_FFFF_FFFF_FFFE, "R11 load");
    idle(64'h0001_0000_0000_0000);
    idle(64'h0001_0000_0000_0000);
    idle('0);
    peek(5'd14, 64'd0, "R7 wrap value");
    peek(5'd18, 64'hA000_0000_0000_0040, "R7 R8 status after wrap");
    chk({63'b0, irq}, 64'd1, "R8 irq raised");

    // R9 write-one-to-clear
    tick(1'b1, 5'd19, 64'd0, '0);
    idle('0);
    peek(5'd18, 64'hA000_0000_0000_0040, "R9 zero write ignored");
    tick(1'b1, 5'd19, 64'h40, '0);
    idle('0);
    peek(5'd18, 64'hA000_0000_0000_0000, "R9 lane flag cleared");
    chk({63'b0, irq}, 64'd1, "R8 irq held");
    tick(1'b1, 5'd19, 64'h2000_0000_0000_0000, '0);
    idle('0);
    chk({63'b0, irq}, 64'd0, "R8 irq cleared");
    peek(5'd18, 64'h8000_0000_0000_0000, "R9 summary cleared");
    tick(1'b1, 5'd19, 64'h8000_0000_0000_0000, '0);
    idle('0);
    peek(5'd18, 64'd0, "R9 change cleared");

    // R9 set and clear in the same cycle
    tick(1'b1, 5'd14, 64'h0000_FFFF_FFFF_FFFF, '0);
    tick(1'b1, 5'd19, 64'hA000_0000_0000_0040, 64'h0001_0000_0000_0000);
    idle('0);
    peek(5'd18, 64'hA000_0000_0000_0040, "R9 set beats clear");
    chk({63'b0, irq}, 64'd1, "R8 irq after collision");
    tick(1'b1, 5'd19, 64'hA000_0001_0000_00FF, '0);
    idle('0);
    peek(5'd18, 64'd0, "R9 all cleared");

    // R11 write beats count
    tick(1'b1, 5'd14, 64'd100, 64'h0005_0000_0000_0000);
    idle('0);
    peek(5'd14, 64'd100, "R11 write wins");

    // R7 fixed counter wrap
    tick(1'b1, 5'd16, 64'h0000_FFFF_FFFF_FFFD, '0);
    tick(1'b1, 5'd17, 64'h0000_0001_0000_006D, '0);
    for (int k = 0; k < 4; k++) idle('0);
    peek(5'd16, 64'd0, "R7 fixed wrap value");
    peek(5'd18, 64'h8000_0001_0000_0000, "R7 fixed flag");
    tick(1'b1, 5'd17, 64'h6D, '0);
    tick(1'b1, 5'd19, 64'hA000_0001_0000_00FF, '0);

    // R10 occupancy clear
    tick(1'b1, 5'd7, 64'h0002_0000, 64'h0900_0000_0000_0000);
    idle(64'h0400_0000_0000_0000);
    idle('0);
    peek(5'd27, 64'd4, "R10 cleared then summed");
    peek(5'd7, 64'd0, "R10 reset bit reads zero");
    tick(1'b1, 5'd7, 64'd0, '0);
    idle('0);
    peek(5'd27, 64'd4, "R10 zero write ignored");

    // random traffic against the model
    for (int k = 0; k < 600; k++) begin
      logic [63:0] ev, d;
      logic [4:0]  a;
      bit          we;
      ev = {$urandom, $urandom};
      d  = {$urandom, $urandom};
      a  = 5'($urandom_range(0, 27));
      we = ($urandom_range(0, 3) == 0);
      tick(we, a, d, ev);
    end
    idle('0);
    idle('0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end
endmodule